// File: doc/BRIEF.md
# Packed Multiply and Absolute-Difference Datapath

This block is a registered SIMD arithmetic stage for a 64-bit media pipeline. It takes two 64-bit operands, splits them into four 16-bit lanes, or eight 8-bit lanes for one mode, and returns one 64-bit result. The modes are:

- per-lane products, keeping either the low or the high half, signed or unsigned;
- pairwise multiply-add into two 32-bit halves;
- a reduction of all four lane products into one 64-bit value;
- sums of absolute differences over bytes or halfwords.

All multiply modes share a single bank of four lane multipliers. The signedness of each operand is steered into the lanes, so no mode needs a multiplier of its own.

A caller presents `op`, `mac_sel` and the operands with `in_valid` high. The result appears on `result`, with a one-cycle `out_valid` pulse, after the next rising clock edge. `result` holds its value until the next accepted operation. The active-low reset is asserted asynchronously. Its release passes through a two-stage synchroniser inside the block, so the caller waits two clocks after releasing reset before issuing work.

Top module: `simd_mul_sad`

## Requirements
- R1: While reset is asserted and after it is released, with no operation accepted yet, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was high, and low after every edge at which `in_valid` was low. Back-to-back operations give back-to-back pulses.
- R3: With `mac_sel`=0 and `op`=0, result[31:0] is the low 32 bits of the sum of the signed products of lane 0 and lane 1 (lane k is bits 16k+15:16k). result[63:32] is built the same way from lanes 2 and 3.
- R4: With `mac_sel`=0 and `op`=1, the pairing is as in R3 but every halfword is taken as unsigned.
- R5: With `mac_sel`=0 and `op`=2, the result is the zero-extended sum over the eight bytes of |a_byte - b_byte|, with the bytes taken as unsigned. The result is never above 2040.
- R6: With `mac_sel`=0 and `op`=3, the result is the zero-extended sum over the four unsigned halfwords of |a_half - b_half|.
- R7: With `mac_sel`=0, each lane of the result holds bits 15:0 of that lane's 16x16 product. `op`=4 takes the product as signed and `op`=5 as unsigned.
- R8: With `mac_sel`=0, each lane of the result holds bits 31:16 of that lane's product. `op`=6 takes the product as signed and `op`=7 as unsigned.
- R9: With `mac_sel`=1 and op[0]=1, the result is the sum of the four unsigned lane products, zero-extended, and is always below 2^34.
- R10: With `mac_sel`=1 and op[0]=0, the result is the sum of the four lane products with a unsigned and b signed, sign-extended to 64 bits. op[2:1] has no effect on either reduction.
- R11: While `in_valid` is low, `result` keeps the value of the last accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| in_valid | input | 1 | Accepts the operation presented this cycle |
| op | input | 3 | Operation code (see R3 to R8); bit 0 selects unsigned for the reductions |
| mac_sel | input | 1 | Selects the four-product reduction instead of `op` |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered result |

## Verification
The bench builds the block with its default parameters: four lanes of 16 bits, which gives eight bytes for the byte mode. At this size the extreme lane values fit in every operand: the most negative value, the most positive value, all ones and zero. That brings the signed-product overflow of the pairwise sum, the sign extension of the signed reduction and the largest possible absolute-difference sums within reach of directed vectors. Random operands are mixed with these lane values, and issue gaps are mixed with back-to-back issue, so that the pulse and hold behaviour is exercised around every mode.

// File: rtl/simd_ms_pkg.sv
package simd_ms_pkg;

  typedef enum logic [2:0] {
    MOP_MADD_S  = 3'd0,
    MOP_MADD_U  = 3'd1,
    MOP_SAD_B   = 3'd2,
    MOP_SAD_H   = 3'd3,
    MOP_MULLO_S = 3'd4,
    MOP_MULLO_U = 3'd5,
    MOP_MULHI_S = 3'd6,
    MOP_MULHI_U = 3'd7
  } mop_e;

endpackage

// File: rtl/sms_lane_mul.sv
// One lane multiplier: operands widened by one bit so that a single signed
// multiplier serves both signed and unsigned interpretations.
module sms_lane_mul #(
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W + 2
) (
  input  logic [LANE_W-1:0]        a_i,
  input  logic [LANE_W-1:0]        b_i,
  input  logic                     a_sgn_i,
  input  logic                     b_sgn_i,
  output logic signed [PROD_W-1:0] prod_o
);

  logic signed [LANE_W:0] a_ext;
  logic signed [LANE_W:0] b_ext;

  always_comb begin
    a_ext  = {a_sgn_i & a_i[LANE_W-1], a_i};
    b_ext  = {b_sgn_i & b_i[LANE_W-1], b_i};
    prod_o = PROD_W'(a_ext) * PROD_W'(b_ext);
  end

endmodule

// File: rtl/sms_absdiff_sum.sv
// Sum of absolute differences over ELEMS unsigned elements of ELEM_W bits.
module sms_absdiff_sum #(
  parameter int ELEM_W = 8,
  parameter int ELEMS  = 8,
  localparam int SUM_W = ELEM_W + $clog2(ELEMS)
) (
  input  logic [ELEM_W*ELEMS-1:0] a_i,
  input  logic [ELEM_W*ELEMS-1:0] b_i,
  output logic [SUM_W-1:0]        sum_o
);

  logic [ELEM_W-1:0] diff [ELEMS];

  for (genvar g = 0; g < ELEMS; g++) begin : g_elem
    logic [ELEM_W-1:0] x;
    logic [ELEM_W-1:0] y;
    assign x = a_i[g*ELEM_W +: ELEM_W];
    assign y = b_i[g*ELEM_W +: ELEM_W];
    assign diff[g] = (x >= y) ? (x - y) : (y - x);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < ELEMS; i++) begin
      sum_o = sum_o + SUM_W'(diff[i]);
    end
  end

endmodule

// File: rtl/sms_datapath.sv
// Combinational lane-partitioned datapath: shared lane multipliers, pair
// adders, a four-product reduction tree and two absolute-difference trees.
module sms_datapath
  import simd_ms_pkg::*;
#(
  parameter int LANE_W    = 16,
  parameter int NUM_LANES = 4,
  localparam int DATA_W   = LANE_W * NUM_LANES,
  localparam int PROD_W   = 2 * LANE_W + 2,
  localparam int PAIR_W   = 2 * LANE_W,
  localparam int RED_W    = PROD_W + $clog2(NUM_LANES),
  localparam int SADB_W   = LANE_W / 2 + $clog2(2 * NUM_LANES),
  localparam int SADH_W   = LANE_W + $clog2(NUM_LANES)
) (
  input  logic [2:0]        op_i,
  input  logic              mac_sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  // op[0] marks every unsigned multiply form; the signed reduction keeps a unsigned.
  logic a_sgn;
  logic b_sgn;
  assign b_sgn = ~op_i[0];
  assign a_sgn = ~op_i[0] & ~mac_sel_i;

  logic signed [PROD_W-1:0] prod [NUM_LANES];
  logic [DATA_W-1:0] mul_lo;
  logic [DATA_W-1:0] mul_hi;
  logic [DATA_W-1:0] madd;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    sms_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .a_sgn_i(a_sgn),
      .b_sgn_i(b_sgn),
      .prod_o (prod[l])
    );
    assign mul_lo[l*LANE_W +: LANE_W] = prod[l][LANE_W-1:0];
    assign mul_hi[l*LANE_W +: LANE_W] = prod[l][2*LANE_W-1:LANE_W];
  end

  for (genvar p = 0; p < NUM_LANES / 2; p++) begin : g_pair
    assign madd[p*PAIR_W +: PAIR_W] = prod[2*p][PAIR_W-1:0] + prod[2*p+1][PAIR_W-1:0];
  end

  logic signed [RED_W-1:0] red;
  always_comb begin
    red = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      red = red + RED_W'(prod[i]);
    end
  end

  logic [SADB_W-1:0] sad_b;
  logic [SADH_W-1:0] sad_h;

  sms_absdiff_sum #(.ELEM_W(LANE_W / 2), .ELEMS(2 * NUM_LANES)) u_sad_b (
    .a_i  (a_i),
    .b_i  (b_i),
    .sum_o(sad_b)
  );

  sms_absdiff_sum #(.ELEM_W(LANE_W), .ELEMS(NUM_LANES)) u_sad_h (
    .a_i  (a_i),
    .b_i  (b_i),
    .sum_o(sad_h)
  );

  always_comb begin
    if (mac_sel_i) begin
      res_o = {{(DATA_W - RED_W){red[RED_W-1]}}, red};
    end else begin
      unique case (mop_e'(op_i))
        MOP_MADD_S, MOP_MADD_U:   res_o = madd;
        MOP_SAD_B:                res_o = {{(DATA_W - SADB_W){1'b0}}, sad_b};
        MOP_SAD_H:                res_o = {{(DATA_W - SADH_W){1'b0}}, sad_h};
        MOP_MULLO_S, MOP_MULLO_U: res_o = mul_lo;
        default:                  res_o = mul_hi;
      endcase
    end
  end

endmodule

// File: rtl/simd_mul_sad.sv
module simd_mul_sad #(
  parameter int LANE_W    = 16,
  parameter int NUM_LANES = 4,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              mac_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DATA_W-1:0] dp_res;

  sms_datapath #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_dp (
    .op_i     (op),
    .mac_sel_i(mac_sel),
    .a_i      (a),
    .b_i      (b),
    .res_o    (dp_res)
  );

  logic              vld_d;
  logic              vld_q;
  logic              res_en;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;

  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    res_d  = dp_res;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

endmodule

// File: rtl/simd_mul_sad_chk.sv
module simd_mul_sad_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              mac_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));  // R11

  AST_SADB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mac_sel && op == 3'd2) |=> (result <= DATA_W'(2040)));  // R5

  AST_SADH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mac_sel && op == 3'd3) |=> (result[DATA_W-1:18] == '0));  // R6

  AST_UREDUCE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mac_sel && op[0]) |=> (result[DATA_W-1:34] == '0));  // R9

endmodule

bind simd_mul_sad simd_mul_sad_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .op       (op),
  .mac_sel  (mac_sel),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/simd_mul_sad_tb.sv
module simd_mul_sad_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic        mac_sel;
  logic [63:0] a;
  logic [63:0] b;
  logic        out_valid;
  logic [63:0] result;

  int n_checks;
  int n_fail;

  simd_mul_sad u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mac_sel(mac_sel),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint lane_val(logic [15:0] v, bit sgn);
    return sgn ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic logic [63:0] model(logic [2:0] o, logic m, logic [63:0] x, logic [63:0] y);
    logic [63:0] r;
    longint acc;
    longint pr;
    logic [63:0] pv;
    r = '0;
    if (m) begin
      acc = 0;
      for (int i = 0; i < 4; i++)
        acc += lane_val(x[16*i +: 16], 1'b0) * lane_val(y[16*i +: 16], !o[0]);
      r = 64'(acc);
    end else if (o == 3'd0 || o == 3'd1) begin
      for (int p = 0; p < 2; p++) begin
        acc = 0;
        for (int j = 0; j < 2; j++)
          acc += lane_val(x[32*p+16*j +: 16], !o[0]) * lane_val(y[32*p+16*j +: 16], !o[0]);
        pv = 64'(acc);
        r[32*p +: 32] = pv[31:0];
      end
    end else if (o == 3'd2) begin
      acc = 0;
      for (int i = 0; i < 8; i++) begin
        pr = longint'(x[8*i +: 8]) - longint'(y[8*i +: 8]);
        acc += (pr < 0) ? -pr : pr;
      end
      r = 64'(acc);
    end else if (o == 3'd3) begin
      acc = 0;
      for (int i = 0; i < 4; i++) begin
        pr = longint'(x[16*i +: 16]) - longint'(y[16*i +: 16]);
        acc += (pr < 0) ? -pr : pr;
      end
      r = 64'(acc);
    end else begin
      for (int i = 0; i < 4; i++) begin
        pr = lane_val(x[16*i +: 16], !o[0]) * lane_val(y[16*i +: 16], !o[0]);
        pv = 64'(pr);
        r[16*i +: 16] = o[1] ? pv[31:16] : pv[15:0];
      end
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] o, logic m);
    if (m) return o[0] ? "R9" : "R10";
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] corner(int k);
    case (k)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [63:0] mix_operand();
    logic [63:0] v;
    for (int i = 0; i < 4; i++) v[16*i +: 16] = corner(int'($urandom % 6));
    return v;
  endfunction

  // Expected outputs for the cycle after the current drive.
  logic        exp_vld;
  logic [63:0] exp_res;
  string       exp_tag;

  task automatic step(logic v, logic [2:0] o, logic m, logic [63:0] x, logic [63:0] y);
    @(negedge clk);
    check(v ? "R2" : "R2 idle", {63'd0, out_valid}, {63'd0, exp_vld});
    check(exp_tag, result, exp_res);
    in_valid = v; op = o; mac_sel = m; a = x; b = y;
    exp_vld = v;
    if (v) begin
      exp_res = model(o, m, x, y);
      exp_tag = tag_of(o, m);
    end else begin
      exp_tag = "R11";
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; mac_sel = 1'b0; a = '0; b = '0;
    exp_vld = 1'b0; exp_res = '0; exp_tag = "R1";
    // R1: state under reset
    repeat (3) begin
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", result, 64'd0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", result, 64'd0);
    end

    // Directed: every mode with uniform corner lane values
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 8; o++)
        for (int ka = 0; ka < 4; ka++)
          for (int kb = 0; kb < 4; kb++)
            step(1'b1, 3'(o), 1'(m), {4{corner(ka)}}, {4{corner(kb)}});

    // Byte-mode extremes: all 0xFF against 0x00 gives 2040 (R5)
    step(1'b1, 3'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    step(1'b1, 3'd2, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    // R10: op[2:1] ignored under mac_sel
    step(1'b1, 3'd6, 1'b1, 64'hFFFF_0001_8000_7FFF, 64'h8000_FFFF_7FFF_0003);
    step(1'b1, 3'd0, 1'b1, 64'hFFFF_0001_8000_7FFF, 64'h8000_FFFF_7FFF_0003);
    // R11: gaps after a result
    repeat (3) step(1'b0, 3'd3, 1'b0, 64'h1234, 64'h5678);

    // Random mixes with gaps
    for (int n = 0; n < 6000; n++)
      step(($urandom % 4) != 0, 3'($urandom), 1'(($urandom % 4) == 0), mix_operand(), mix_operand());

    step(1'b0, 3'd0, 1'b0, '0, '0);
    step(1'b0, 3'd0, 1'b0, '0, '0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule